// File: doc/BRIEF.md
# Memory Power-Down Sequencer

This block belongs to the command path of a double-data-rate memory controller. It decides when the clock-enable line may fall so that the memory can enter power-down. It also decides when ordinary commands may be issued again after the line rises. The block watches the command stream and keeps a single guard counter. Each issued command reloads that counter with the longest interval still owed before the clock-enable may fall. When the counter is clear and the controller asks for idle, the block lowers clock-enable.

At entry the block records the kind of power-down from the open-row map and the exit-speed bit. If no row is open, the kind is precharge power-down. If a row is open and the bit is clear, the kind is active power-down with fast exit. If a row is open and the bit is set, the kind is active power-down with slow exit. That recorded kind selects which exit latency is counted after clock-enable rises. A duration counter forces the exit before nine refresh intervals have passed, even while the idle request is still held.

The state machine has three states. ST_UP means clock-enable is high and commands are allowed. ST_SLEEP means clock-enable is low. ST_WAKE means clock-enable is high and the exit latency is being counted. The transitions are:
- enter: ST_UP to ST_SLEEP, on the idle request while entry is permitted.
- wake: ST_SLEEP to ST_WAKE, when the idle request drops or the duration limit is reached.
- resume: ST_WAKE to ST_UP, when the exit counter finishes.

Top module: `pdn_ctrl`

## Requirements
- R1: After reset the block shows cke=1, cmd_ready=1 and pd_type=0. With cmd_code=0 it also shows entry_ok=1.
- R2: Command codes are 0=NOP/deselect, 1=activate, 2=precharge, 3=read, 4=read with auto-precharge, 5=write, 6=write with auto-precharge, 7=refresh and 8=mode-register set. In the cycle a non-zero code is presented, entry_ok is 0. After activate, precharge or refresh alone, entry_ok is 1 in the next cycle.
- R3: Each guarded command presented in cycle c has an interval N. For read and read with auto-precharge, N = cfg_rl + cfg_bl/2. When only NOPs follow, entry_ok is 0 through cycle c+max(N,1)-1 and is 1 from cycle c+max(N,1).
- R4: For write, N = cfg_wl + cfg_bl/2 + cfg_twtr, with the same timing as R3.
- R5: For write with auto-precharge, N = cfg_wl + cfg_bl/2 + cfg_wr, with the same timing as R3.
- R6: For mode-register set, N = cfg_tmrd, with the same timing as R3.
- R7: A later command never shortens an interval still owed. entry_ok rises at the latest end among all pending intervals.
- R8: If idle_req=1 and entry_ok=1 in cycle t, then from cycle t+1 the block shows cke=0, cmd_ready=0 and entry_ok=0. If idle_req is high while entry_ok=0, cke stays 1 until the first cycle in which entry_ok is 1.
- R9: pd_type is taken from the inputs of the entry cycle. The value is 1 if bank_open is all zero, whatever cfg_slow_exit is. The value is 2 if any bank is open and cfg_slow_exit=0. The value is 3 if any bank is open and cfg_slow_exit=1. pd_type holds while cke is low and during the exit latency, then returns to 0.
- R10: If idle_req is 0 in a cycle u while cke is low, cke is 1 from cycle u+1. cmd_ready is then 0 in cycles u+1 to u+L and 1 from cycle u+L+1. L is the larger of 1 and the latency that pd_type selects: cfg_txp for type 1, cfg_txard for type 2, cfg_txards for type 3. While cmd_ready is 0, only code 0 may be presented.
- R11: cke stays low for at most 9*cfg_trefi consecutive cycles, or 1 cycle if cfg_trefi is 0. After that many cycles it rises even with idle_req held high, and the exit latency of R10 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_code | input | 4 | Command issued this cycle, encoded as in R2 |
| bank_open | input | NBANK | One bit per bank, set while that bank holds an open row |
| idle_req | input | 1 | Request to stay in power-down |
| cfg_rl | input | TW | Read latency in cycles |
| cfg_wl | input | TW | Write latency in cycles |
| cfg_bl | input | TW | Burst length in beats |
| cfg_twtr | input | TW | Write-to-read turnaround in cycles |
| cfg_wr | input | TW | Write recovery in cycles |
| cfg_tmrd | input | TW | Mode-register set command time in cycles |
| cfg_txp | input | TW | Exit latency for precharge power-down |
| cfg_txard | input | TW | Exit latency for fast-exit active power-down |
| cfg_txards | input | TW | Exit latency for slow-exit active power-down |
| cfg_slow_exit | input | 1 | Exit-speed bit for active power-down: 1 selects slow exit |
| cfg_trefi | input | REFW | Refresh interval in cycles |
| cke | output | 1 | Clock-enable to the memory |
| entry_ok | output | 1 | Power-down entry permitted this cycle |
| pd_type | output | 2 | Current power-down kind, encoded as in R9 |
| cmd_ready | output | 1 | Ordinary commands may be issued |

## Verification
All results are counted from the cycle in which an input is presented. entry_ok is combinational and is due max(N,1) cycles after a guarded command. cke falls one cycle after the entry cycle, and rises one cycle after idle_req drops. cmd_ready follows L further cycles after cke rises. The bench applies inputs on the falling edge and samples one nanosecond later, so every sample sees the state left by the preceding rising edge together with the current inputs. Each task walks cycle by cycle and checks every cycle inside a window, not just its end, so an early or late edge is caught as a mismatch.

// File: rtl/pdn_pkg.sv
`timescale 1ns/1ps
package pdn_pkg;
    typedef enum logic [3:0] {
        CMD_NOP = 4'd0,
        CMD_ACT = 4'd1,
        CMD_PRE = 4'd2,
        CMD_RD  = 4'd3,
        CMD_RDA = 4'd4,
        CMD_WR  = 4'd5,
        CMD_WRA = 4'd6,
        CMD_REF = 4'd7,
        CMD_MRS = 4'd8
    } pdn_cmd_e;

    typedef enum logic [1:0] {
        PDT_NONE     = 2'd0,
        PDT_PRECH    = 2'd1,
        PDT_ACT_FAST = 2'd2,
        PDT_ACT_SLOW = 2'd3
    } pdn_type_e;

    typedef enum logic [1:0] {
        ST_UP    = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } pdn_state_e;
endpackage

// File: rtl/pdn_guard.sv
`timescale 1ns/1ps
module pdn_guard #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cmd_code,
    input  logic [TW-1:0] cfg_rl,
    input  logic [TW-1:0] cfg_wl,
    input  logic [TW-1:0] cfg_bl,
    input  logic [TW-1:0] cfg_twtr,
    input  logic [TW-1:0] cfg_wr,
    input  logic [TW-1:0] cfg_tmrd,
    output logic          guard_clear
);
    import pdn_pkg::*;

    localparam int GW = TW + 2;

    logic [GW-1:0] guard_q;
    logic [GW-1:0] half_burst;
    logic [GW-1:0] need;
    logic [GW-1:0] need_m1;
    logic [GW-1:0] base;
    logic [GW-1:0] guard_n;

    // interval owed by the command on the bus this cycle
    always_comb begin
        half_burst = GW'(cfg_bl >> 1);
        case (pdn_cmd_e'(cmd_code))
            CMD_RD, CMD_RDA: need = GW'(cfg_rl) + half_burst;
            CMD_WR:          need = GW'(cfg_wl) + half_burst + GW'(cfg_twtr);
            CMD_WRA:         need = GW'(cfg_wl) + half_burst + GW'(cfg_wr);
            CMD_MRS:         need = GW'(cfg_tmrd);
            default:         need = '0;
        endcase
        need_m1 = (need == '0) ? '0 : need - 1'b1;
        base    = (guard_q == '0) ? '0 : guard_q - 1'b1;
        if (cmd_code != 4'd0 && need_m1 > base) begin
            guard_n = need_m1;
        end else begin
            guard_n = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guard_q <= '0;
        end else begin
            guard_q <= guard_n;
        end
    end

    assign guard_clear = (guard_q == '0);
endmodule

// File: rtl/pdn_exit_timer.sv
`timescale 1ns/1ps
module pdn_exit_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [TW-1:0] latency,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= latency;
        end else if (run && cnt_q > TW'(1)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // a latency of zero still costs one cycle with cke high
    assign done = run && (cnt_q <= TW'(1));
endmodule

// File: rtl/pdn_dur_timer.sv
`timescale 1ns/1ps
module pdn_dur_timer #(
    parameter int REFW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic [REFW-1:0] cfg_trefi,
    output logic            expire
);
    localparam int DW = REFW + 4;

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] limit;
    logic [DW-1:0] last;

    always_comb begin
        limit = DW'(cfg_trefi) * DW'(9);
        last  = (limit == '0) ? '0 : limit - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (cnt_q != last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = active && (cnt_q == last);
endmodule

// File: rtl/pdn_ctrl.sv
`timescale 1ns/1ps
module pdn_ctrl #(
    parameter int NBANK = 8,
    parameter int TW    = 8,
    parameter int REFW  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cmd_code,
    input  logic [NBANK-1:0] bank_open,
    input  logic             idle_req,
    input  logic [TW-1:0]    cfg_rl,
    input  logic [TW-1:0]    cfg_wl,
    input  logic [TW-1:0]    cfg_bl,
    input  logic [TW-1:0]    cfg_twtr,
    input  logic [TW-1:0]    cfg_wr,
    input  logic [TW-1:0]    cfg_tmrd,
    input  logic [TW-1:0]    cfg_txp,
    input  logic [TW-1:0]    cfg_txard,
    input  logic [TW-1:0]    cfg_txards,
    input  logic             cfg_slow_exit,
    input  logic [REFW-1:0]  cfg_trefi,
    output logic             cke,
    output logic             entry_ok,
    output logic [1:0]       pd_type,
    output logic             cmd_ready
);
    import pdn_pkg::*;

    pdn_state_e state_q, state_n;
    pdn_type_e  type_q, type_n;
    logic       guard_clear;
    logic       exit_done;
    logic       dur_expire;
    logic       go_sleep;
    logic       go_wake;
    logic [TW-1:0] exit_lat;

    pdn_guard #(.TW(TW)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_code    (cmd_code),
        .cfg_rl      (cfg_rl),
        .cfg_wl      (cfg_wl),
        .cfg_bl      (cfg_bl),
        .cfg_twtr    (cfg_twtr),
        .cfg_wr      (cfg_wr),
        .cfg_tmrd    (cfg_tmrd),
        .guard_clear (guard_clear)
    );

    pdn_dur_timer #(.REFW(REFW)) u_dur (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state_q == ST_SLEEP),
        .cfg_trefi (cfg_trefi),
        .expire    (dur_expire)
    );

    pdn_exit_timer #(.TW(TW)) u_exit (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (go_wake),
        .run     (state_q == ST_WAKE),
        .latency (exit_lat),
        .done    (exit_done)
    );

    // latency chosen by the kind recorded at entry
    always_comb begin
        unique case (type_q)
            PDT_ACT_FAST: exit_lat = cfg_txard;
            PDT_ACT_SLOW: exit_lat = cfg_txards;
            default:      exit_lat = cfg_txp;
        endcase
    end

    assign entry_ok = (state_q == ST_UP) && guard_clear && (cmd_code == 4'd0);
    assign go_sleep = idle_req && entry_ok;
    assign go_wake  = (state_q == ST_SLEEP) && (!idle_req || dur_expire);

    // next state and recorded kind
    always_comb begin
        state_n = state_q;
        type_n  = type_q;
        unique case (state_q)
            ST_UP: begin
                if (go_sleep) begin
                    state_n = ST_SLEEP;
                    if (bank_open == '0) begin
                        type_n = PDT_PRECH;
                    end else if (cfg_slow_exit) begin
                        type_n = PDT_ACT_SLOW;
                    end else begin
                        type_n = PDT_ACT_FAST;
                    end
                end
            end
            ST_SLEEP: begin
                if (go_wake) begin
                    state_n = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (exit_done) begin
                    state_n = ST_UP;
                    type_n  = PDT_NONE;
                end
            end
            default: begin
                state_n = ST_UP;
                type_n  = PDT_NONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UP;
            type_q  <= PDT_NONE;
        end else begin
            state_q <= state_n;
            type_q  <= type_n;
        end
    end

    // outputs decoded from the state register
    always_comb begin
        cke       = 1'b1;
        cmd_ready = 1'b0;
        unique case (state_q)
            ST_UP:    cmd_ready = 1'b1;
            ST_SLEEP: cke = 1'b0;
            ST_WAKE:  cmd_ready = 1'b0;
            default:  cmd_ready = 1'b0;
        endcase
        pd_type = type_q;
    end
endmodule

// File: rtl/pdn_ctrl_chk.sv
`timescale 1ns/1ps
module pdn_ctrl_chk #(
    parameter int NBANK = 8,
    parameter int REFW  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       cmd_code,
    input logic [NBANK-1:0] bank_open,
    input logic             idle_req,
    input logic [REFW-1:0]  cfg_trefi,
    input logic             cke,
    input logic             entry_ok,
    input logic [1:0]       pd_type,
    input logic             cmd_ready
);
    localparam int CW = REFW + 5;

    logic [CW-1:0] low_run;
    logic [CW-1:0] low_limit;

    assign low_limit = (cfg_trefi == '0) ? CW'(1) : CW'(cfg_trefi) * CW'(9);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!cke) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    AST_FALL_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(entry_ok && idle_req)); // R8
    AST_PRECH_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cke) && $past(bank_open) == '0) |-> pd_type == 2'd1); // R9
    AST_ACTIVE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cke) && $past(bank_open) != '0) |-> pd_type[1]); // R9
    AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> $stable(pd_type)); // R9
    AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !cmd_ready); // R10
    AST_READY_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> cke); // R10
    AST_QUIET_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |-> cmd_code == 4'd0); // R10
    AST_LOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= low_limit); // R11
endmodule

bind pdn_ctrl pdn_ctrl_chk #(.NBANK(NBANK), .REFW(REFW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_code  (cmd_code),
    .bank_open (bank_open),
    .idle_req  (idle_req),
    .cfg_trefi (cfg_trefi),
    .cke       (cke),
    .entry_ok  (entry_ok),
    .pd_type   (pd_type),
    .cmd_ready (cmd_ready)
);

// File: tb/pdn_ctrl_test.sv
`timescale 1ns/1ps
module pdn_ctrl_test;
    localparam int NBANK = 8;
    localparam int TW    = 8;
    localparam int REFW  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       cmd_code = 4'd0;
    logic [NBANK-1:0] bank_open = '0;
    logic             idle_req = 1'b0;
    logic [TW-1:0]    cfg_rl = 8'd5;
    logic [TW-1:0]    cfg_wl = 8'd4;
    logic [TW-1:0]    cfg_bl = 8'd8;
    logic [TW-1:0]    cfg_twtr = 8'd3;
    logic [TW-1:0]    cfg_wr = 8'd6;
    logic [TW-1:0]    cfg_tmrd = 8'd2;
    logic [TW-1:0]    cfg_txp = 8'd3;
    logic [TW-1:0]    cfg_txard = 8'd2;
    logic [TW-1:0]    cfg_txards = 8'd7;
    logic             cfg_slow_exit = 1'b0;
    logic [REFW-1:0]  cfg_trefi = 16'd4;
    logic             cke;
    logic             entry_ok;
    logic [1:0]       pd_type;
    logic             cmd_ready;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    pdn_ctrl #(.NBANK(NBANK), .TW(TW), .REFW(REFW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .bank_open(bank_open),
        .idle_req(idle_req), .cfg_rl(cfg_rl), .cfg_wl(cfg_wl), .cfg_bl(cfg_bl),
        .cfg_twtr(cfg_twtr), .cfg_wr(cfg_wr), .cfg_tmrd(cfg_tmrd),
        .cfg_txp(cfg_txp), .cfg_txard(cfg_txard), .cfg_txards(cfg_txards),
        .cfg_slow_exit(cfg_slow_exit), .cfg_trefi(cfg_trefi),
        .cke(cke), .entry_ok(entry_ok), .pd_type(pd_type), .cmd_ready(cmd_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // move to the next cycle: inputs change at the falling edge, samples follow 1 ns later
    task automatic next_cycle();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) next_cycle();
        rst_n = 1'b1;
        next_cycle();
        settle();
        chk("R1 cke", int'(cke), 1);
        chk("R1 cmd_ready", int'(cmd_ready), 1);
        chk("R1 pd_type", int'(pd_type), 0);
        chk("R1 entry_ok", int'(entry_ok), 1);
    endtask

    // command in cycle c, then NOPs; entry_ok must rise exactly at c+max(n,1)
    task automatic t_guard(input string req, input logic [3:0] code, input int n);
        int lim;
        lim = (n > 0) ? n : 1;
        next_cycle();
        cmd_code = code;
        idle_req = 1'b0;
        settle();
        chk({req, " command cycle"}, int'(entry_ok), 0);
        for (int k = 1; k <= lim + 2; k++) begin
            next_cycle();
            cmd_code = 4'd0;
            settle();
            chk({req, " window"}, int'(entry_ok), (k >= lim) ? 1 : 0);
        end
    endtask

    // R7: a first command at offset 0, a second at offset d2; rise is due at the later end
    task automatic t_overlap(input logic [3:0] c1, input int n1, input logic [3:0] c2,
                             input int d2, input int n2);
        int due;
        due = (n1 > d2 + n2) ? n1 : d2 + n2;
        next_cycle();
        cmd_code = c1;
        settle();
        for (int k = 1; k <= due + 1; k++) begin
            next_cycle();
            cmd_code = (k == d2) ? c2 : 4'd0;
            settle();
            if (k != d2) begin
                chk("R7 overlap", int'(entry_ok), (k >= due) ? 1 : 0);
            end
        end
    endtask

    // enter with given bank map and exit bit, stay hold cycles, then drop idle_req
    task automatic t_sleep(input string req, input logic [NBANK-1:0] banks,
                           input logic slow, input int exp_type, input int lat,
                           input int hold);
        next_cycle();
        cmd_code = 4'd0;
        bank_open = banks;
        cfg_slow_exit = slow;
        idle_req = 1'b1;
        settle();
        chk("R8 entry permitted", int'(entry_ok), 1);
        for (int k = 1; k <= hold; k++) begin
            next_cycle();
            bank_open = ~banks; // changes after entry must not alter the kind
            cfg_slow_exit = ~slow;
            if (k == hold) idle_req = 1'b0;
            settle();
            chk("R8 cke low", int'(cke), 0);
            chk("R8 not ready", int'(cmd_ready), 0);
            chk({req, " kind"}, int'(pd_type), exp_type);
        end
        for (int j = 1; j <= lat; j++) begin
            next_cycle();
            settle();
            chk("R10 cke high", int'(cke), 1);
            chk("R10 latency", int'(cmd_ready), 0);
            chk("R9 kind during exit", int'(pd_type), exp_type);
        end
        next_cycle();
        settle();
        chk("R10 ready", int'(cmd_ready), 1);
        chk("R9 kind cleared", int'(pd_type), 0);
        bank_open = '0;
        cfg_slow_exit = 1'b0;
    endtask

    // R8: idle requested while a read guard is pending
    task automatic t_wait_entry();
        next_cycle();
        cmd_code = 4'd3;
        idle_req = 1'b1;
        bank_open = '0;
        settle();
        for (int k = 1; k <= 10; k++) begin
            next_cycle();
            cmd_code = 4'd0;
            if (k == 10) idle_req = 1'b0;
            settle();
            chk("R8 deferred entry", int'(cke), (k == 10) ? 0 : 1);
        end
        for (int j = 1; j <= 3; j++) begin
            next_cycle();
            settle();
            chk("R10 txp wait", int'(cmd_ready), 0);
        end
        next_cycle();
        settle();
        chk("R10 txp ready", int'(cmd_ready), 1);
    endtask

    // R11: idle held; cke must rise after 9*trefi low cycles
    task automatic t_max_dur();
        int low_cnt;
        low_cnt = 0;
        next_cycle();
        cmd_code = 4'd0;
        bank_open = 8'h04;
        cfg_slow_exit = 1'b0;
        idle_req = 1'b1;
        settle();
        for (int k = 0; k < 200; k++) begin
            next_cycle();
            settle();
            if (cke) break;
            low_cnt++;
        end
        idle_req = 1'b0;
        chk("R11 low cycles", low_cnt, 9 * int'(cfg_trefi));
        chk("R11 exit not ready", int'(cmd_ready), 0);
        next_cycle();
        settle();
        chk("R11 fast exit wait", int'(cmd_ready), 0);
        next_cycle();
        settle();
        chk("R11 fast exit ready", int'(cmd_ready), 1);
        bank_open = '0;
    endtask

    initial begin
        t_reset();
        t_guard("R2 activate", 4'd1, 0);
        t_guard("R2 precharge", 4'd2, 0);
        t_guard("R2 refresh", 4'd7, 0);
        t_guard("R3 read", 4'd3, 9);
        t_guard("R3 read autoprecharge", 4'd4, 9);
        t_guard("R4 write", 4'd5, 11);
        t_guard("R5 write autoprecharge", 4'd6, 14);
        t_guard("R6 mode set", 4'd8, 2);
        t_overlap(4'd5, 11, 4'd8, 2, 2);
        t_overlap(4'd3, 9, 4'd6, 3, 14);
        t_overlap(4'd3, 9, 4'd1, 2, 0);
        t_sleep("R9 precharge", 8'h00, 1'b0, 1, 3, 4);
        t_sleep("R9 precharge slow bit", 8'h00, 1'b1, 1, 3, 2);
        t_sleep("R9 active fast", 8'h10, 1'b0, 2, 2, 3);
        t_sleep("R9 active slow", 8'h81, 1'b1, 3, 7, 1);
        t_wait_entry();
        t_max_dur();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule